// File: doc/BRIEF.md
# Upward-Growing Call Stack Unit

This block keeps an 8-bit stack pointer over a 256-byte data RAM that it contains. It saves and restores processor context for a CPU core. A command port accepts single-byte pushes and pops. It also accepts multi-byte sequences:

- a subroutine call, which saves a 16-bit return address;
- a subroutine return, which restores that address;
- interrupt entry, which saves the return address and then the status byte;
- return-from-interrupt, which restores both.

The stack grows toward higher addresses. The pointer always names the top entry. A push increments the pointer first and then writes. A pop reads at the pointer and then decrements it.

The block also holds the status byte: four condition flags written by an external ALU, and two interrupt-enable bits. The four flags are also brought out on their own for conditional-branch evaluation. A load port sets the pointer to any value, so the stack can sit anywhere in the RAM. Multi-byte sequences take one clock per byte. While one runs, `busy` is high and new commands are ignored.

Top module: `call_stack_unit`

## Requirements
- R1: After a synchronous reset, `sp` = 0x01, `status` = 0x00, `cond_flags` = 0, `busy` = 0 and `wrap_err` = 0.
- R2: An accepted push (`cmd_op` = 1) writes `cmd_data` at `sp`+1, and `sp` becomes `sp`+1 after that clock edge.
- R3: An accepted pop (`cmd_op` = 2) returns the byte at `sp` on `pop_data`, with `pop_valid` high for one cycle after the edge, and `sp` becomes `sp`-1. Bytes come back in last-in, first-out order.
- R4: `sp_load` loads `sp_load_val` on the next edge when `busy` is low. It takes priority over a command in the same cycle, and that command is dropped. While `busy` is high, `sp_load` is ignored.
- R5: A call (`cmd_op` = 3) pushes `cmd_ret_addr[7:0]` and then `cmd_ret_addr[15:8]`, one per clock. `busy` is high for the one cycle between the two pushes.
- R6: A return (`cmd_op` = 5) pops the high byte and then the low byte. `ret_addr` is presented with a one-cycle `ret_valid` pulse after the second pop.
- R7: Interrupt entry (`cmd_op` = 4) pushes the address low byte, the address high byte and the status byte, in that order, over three clocks. `busy` is high for two cycles. The status byte saved is the value before entry. Afterwards both enable bits are zero.
- R8: Return-from-interrupt (`cmd_op` = 6) pops the status byte first and restores all six status bits from it. It then pops the high and low address bytes, and `ret_addr`/`ret_valid` follow the third pop.
- R9: The `status` bit layout is: 7 carry, 6 negative, 5 zero, 4 overflow, 3 level-2 enable, 2 level-1 enable. Bits 1:0 always read zero. `flag_we` loads `flag_in` = {C,N,Z,V} and `ie_we` loads `ie_in` = {IE2,IE1}. `cond_flags` = `status[7:4]`.
- R10: The pointer wraps modulo 256: a push at 0xFF gives 0x00, and a pop at 0x00 gives 0xFF. Either event sets `wrap_err`, which stays set until reset.
- R11: A command presented while `busy` is high has no effect on the pointer, the RAM or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 push, 2 pop, 3 call, 4 interrupt entry, 5 return, 6 return-from-interrupt |
| cmd_data | input | 8 | Byte to push |
| cmd_ret_addr | input | 16 | Return address for call or interrupt entry |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 8 | Value to load |
| flag_we | input | 1 | Write the condition flags |
| flag_in | input | 4 | {C,N,Z,V} from the ALU |
| ie_we | input | 1 | Write the interrupt enables |
| ie_in | input | 2 | {IE2,IE1} |
| sp | output | 8 | Stack pointer (top entry) |
| status | output | 8 | Status byte |
| cond_flags | output | 4 | {C,N,Z,V} |
| busy | output | 1 | A multi-byte sequence is in progress |
| pop_valid | output | 1 | `pop_data` holds a popped byte |
| pop_data | output | 8 | Popped byte |
| ret_valid | output | 1 | `ret_addr` holds a restored address |
| ret_addr | output | 16 | Restored return address |
| wrap_err | output | 1 | Sticky pointer wrap indicator |

## Verification
The bound checker watches, on every cycle:

- the one-step pointer movement of accepted pushes and pops;
- the pointer load and its priority;
- the exact busy lengths of call and interrupt entry;
- the reset values;
- the zero padding bits;
- the stickiness of the wrap flag.

Byte order on the stack, last-in, first-out data integrity, the restored address and status values, the clearing of the enables on interrupt entry, and the dropping of commands during `busy` depend on stored contents. Only the bench scenarios can show these, by reading them back through pops and returns.

// File: rtl/cstk_pkg.sv
package cstk_pkg;
    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_IRQ  = 3'd4,
        OP_RET  = 3'd5,
        OP_RETI = 3'd6
    } stk_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CALL_HI,
        SQ_IRQ_HI,
        SQ_IRQ_ST,
        SQ_RET_LO,
        SQ_RETI_HI,
        SQ_RETI_LO
    } seq_state_e;

    typedef enum logic [1:0] {WS_DATA, WS_ALO, WS_AHI, WS_STAT} wr_src_e;
    typedef enum logic [1:0] {RD_BYTE, RD_AHI, RD_ALO, RD_STAT} rd_dst_e;

    typedef struct packed {
        logic    push;
        logic    pop;
        wr_src_e src;
        rd_dst_e dst;
        logic    clr_ie;
    } uop_t;

    typedef struct packed {
        logic       c;
        logic       n;
        logic       z;
        logic       v;
        logic       ie2;
        logic       ie1;
        logic [1:0] pad;
    } stat_t;

    function automatic stat_t to_stat(input logic [BYTE_W-1:0] b);
        stat_t s;
        s = stat_t'(b);
        s.pad = 2'b00;
        return s;
    endfunction
endpackage

// File: rtl/cstk_ram.sv
module cstk_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cstk_ptr.sv
module cstk_ptr #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld,
    input  logic [SP_W-1:0] ld_val,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_next,
    output logic            wrap_err
);
    localparam logic [SP_W-1:0] SP_RST = {{(SP_W-1){1'b0}}, 1'b1};
    localparam logic [SP_W-1:0] SP_MAX = {SP_W{1'b1}};

    assign sp_next = sp + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp       <= SP_RST;
            wrap_err <= 1'b0;
        end else if (ld) begin
            sp <= ld_val;
        end else if (inc) begin
            sp <= sp_next;
            if (sp == SP_MAX) wrap_err <= 1'b1;
        end else if (dec) begin
            sp <= sp - 1'b1;
            if (sp == '0) wrap_err <= 1'b1;
        end
    end
endmodule

// File: rtl/cstk_status.sv
module cstk_status
    import cstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_we,
    input  logic [3:0]        flag_in,
    input  logic              ie_we,
    input  logic [1:0]        ie_in,
    input  logic              restore,
    input  logic [BYTE_W-1:0] restore_val,
    input  logic              clr_ie,
    output stat_t             st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (restore) begin
            st <= to_stat(restore_val);
        end else begin
            if (flag_we) {st.c, st.n, st.z, st.v} <= flag_in;
            if (clr_ie)     {st.ie2, st.ie1} <= 2'b00;
            else if (ie_we) {st.ie2, st.ie1} <= ie_in;
        end
    end
endmodule

// File: rtl/cstk_seq.sv
module cstk_seq
    import cstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  stk_op_e           cmd_op,
    input  logic              hold,
    input  logic [BYTE_W-1:0] addr_hi_in,
    output uop_t              uop,
    output logic              busy,
    output logic [BYTE_W-1:0] addr_hi
);
    seq_state_e state, state_nx;
    logic       accept;

    assign busy   = (state != SQ_IDLE);
    assign accept = cmd_valid && !busy && !hold;

    always_comb begin
        uop      = '0;
        state_nx = state;
        case (state)
            SQ_IDLE: begin
                if (accept) begin
                    case (cmd_op)
                        OP_PUSH: begin uop.push = 1'b1; uop.src = WS_DATA; end
                        OP_POP:  begin uop.pop = 1'b1; uop.dst = RD_BYTE; end
                        OP_CALL: begin uop.push = 1'b1; uop.src = WS_ALO; state_nx = SQ_CALL_HI; end
                        OP_IRQ:  begin uop.push = 1'b1; uop.src = WS_ALO; state_nx = SQ_IRQ_HI; end
                        OP_RET:  begin uop.pop = 1'b1; uop.dst = RD_AHI; state_nx = SQ_RET_LO; end
                        OP_RETI: begin uop.pop = 1'b1; uop.dst = RD_STAT; state_nx = SQ_RETI_HI; end
                        default: ;
                    endcase
                end
            end
            SQ_CALL_HI: begin uop.push = 1'b1; uop.src = WS_AHI; state_nx = SQ_IDLE; end
            SQ_IRQ_HI:  begin uop.push = 1'b1; uop.src = WS_AHI; state_nx = SQ_IRQ_ST; end
            SQ_IRQ_ST:  begin uop.push = 1'b1; uop.src = WS_STAT; uop.clr_ie = 1'b1; state_nx = SQ_IDLE; end
            SQ_RET_LO:  begin uop.pop = 1'b1; uop.dst = RD_ALO; state_nx = SQ_IDLE; end
            SQ_RETI_HI: begin uop.pop = 1'b1; uop.dst = RD_AHI; state_nx = SQ_RETI_LO; end
            SQ_RETI_LO: begin uop.pop = 1'b1; uop.dst = RD_ALO; state_nx = SQ_IDLE; end
            default:    state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (accept && (cmd_op == OP_CALL || cmd_op == OP_IRQ))
            addr_hi <= addr_hi_in;
    end
endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit
    import cstk_pkg::*;
#(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [7:0]      cmd_data,
    input  logic [15:0]     cmd_ret_addr,
    input  logic            sp_load,
    input  logic [SP_W-1:0] sp_load_val,
    input  logic            flag_we,
    input  logic [3:0]      flag_in,
    input  logic            ie_we,
    input  logic [1:0]      ie_in,
    output logic [SP_W-1:0] sp,
    output logic [7:0]      status,
    output logic [3:0]      cond_flags,
    output logic            busy,
    output logic            pop_valid,
    output logic [7:0]      pop_data,
    output logic            ret_valid,
    output logic [15:0]     ret_addr,
    output logic            wrap_err
);
    uop_t              uop;
    stat_t             st;
    logic [SP_W-1:0]   sp_next;
    logic [BYTE_W-1:0] addr_hi;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] rdata;
    logic [BYTE_W-1:0] ret_hi;
    logic              ld_en;

    assign ld_en = sp_load && !busy;

    cstk_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (stk_op_e'(cmd_op)),
        .hold       (sp_load),
        .addr_hi_in (cmd_ret_addr[PC_W-1:BYTE_W]),
        .uop        (uop),
        .busy       (busy),
        .addr_hi    (addr_hi)
    );

    cstk_ptr #(.SP_W(SP_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld_en),
        .ld_val   (sp_load_val),
        .inc      (uop.push),
        .dec      (uop.pop),
        .sp       (sp),
        .sp_next  (sp_next),
        .wrap_err (wrap_err)
    );

    always_comb begin
        case (uop.src)
            WS_ALO:  wdata = cmd_ret_addr[BYTE_W-1:0];
            WS_AHI:  wdata = addr_hi;
            WS_STAT: wdata = st;
            default: wdata = cmd_data;
        endcase
    end

    cstk_ram #(.AW(SP_W), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (uop.push),
        .waddr (sp_next),
        .wdata (wdata),
        .raddr (sp),
        .rdata (rdata)
    );

    cstk_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .flag_we     (flag_we),
        .flag_in     (flag_in),
        .ie_we       (ie_we),
        .ie_in       (ie_in),
        .restore     (uop.pop && uop.dst == RD_STAT),
        .restore_val (rdata),
        .clr_ie      (uop.clr_ie),
        .st          (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_valid <= 1'b0;
            ret_valid <= 1'b0;
            pop_data  <= '0;
            ret_hi    <= '0;
            ret_addr  <= '0;
        end else begin
            pop_valid <= uop.pop && uop.dst == RD_BYTE;
            ret_valid <= uop.pop && uop.dst == RD_ALO;
            if (uop.pop && uop.dst == RD_BYTE) pop_data <= rdata;
            if (uop.pop && uop.dst == RD_AHI)  ret_hi   <= rdata;
            if (uop.pop && uop.dst == RD_ALO)  ret_addr <= {ret_hi, rdata};
        end
    end

    assign status     = st;
    assign cond_flags = {st.c, st.n, st.z, st.v};
endmodule

// File: rtl/cstk_chk.sv
module cstk_chk #(
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic            sp_load,
    input logic [SP_W-1:0] sp_load_val,
    input logic            busy,
    input logic [SP_W-1:0] sp,
    input logic [7:0]      status,
    input logic            pop_valid,
    input logic            wrap_err
);
    logic acc;
    assign acc = cmd_valid && !busy && !sp_load;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp == SP_W'(1) && status == 8'h00 && !busy && !wrap_err));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd1) |=> (sp == SP_W'($past(sp) + 1'b1)));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd2) |=> (pop_valid && sp == SP_W'($past(sp) - 1'b1)));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_load && !busy) |=> (sp == $past(sp_load_val)));

    // R5
    call_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd3) |=> busy ##1 !busy);

    // R7
    irq_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd4) |=> busy ##1 busy ##1 !busy);

    // R9
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status[1:0] == 2'b00);

    // R10
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_err |=> wrap_err);
endmodule

bind call_stack_unit cstk_chk #(.SP_W(SP_W)) u_chk (.*);

// File: tb/call_stack_unit_bench.sv
`timescale 1ns/1ps
module call_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_data = 8'h00;
    logic [15:0] cmd_ret_addr = 16'h0000;
    logic        sp_load = 1'b0;
    logic [7:0]  sp_load_val = 8'h00;
    logic        flag_we = 1'b0;
    logic [3:0]  flag_in = 4'h0;
    logic        ie_we = 1'b0;
    logic [1:0]  ie_in = 2'b00;
    logic [7:0]  sp, status, pop_data;
    logic [3:0]  cond_flags;
    logic        busy, pop_valid, ret_valid, wrap_err;
    logic [15:0] ret_addr;

    int checks = 0;
    int errors = 0;
    bit          exp_kind[$];
    logic [15:0] exp_val[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    call_stack_unit u_call_stack_unit (.*);

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_item(bit kind, logic [15:0] v, string tag);
        exp_kind.push_back(kind);
        exp_val.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic take(bit kind, logic [15:0] v);
        if (exp_val.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R3/R6 unexpected output kind=%0d actual=%h expected=none", kind, v);
        end else begin
            bit          k = exp_kind.pop_front();
            logic [15:0] e = exp_val.pop_front();
            string       t = exp_tag.pop_front();
            check({t, " kind"}, 16'(kind), 16'(k));
            check(t, v, e);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (pop_valid) take(1'b0, {8'h00, pop_data});
            if (ret_valid) take(1'b1, ret_addr);
        end
    end

    task automatic issue(logic [2:0] op, logic [7:0] d, logic [15:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_ret_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        while (busy) @(negedge clk);
    endtask

    task automatic load_sp(logic [7:0] v);
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
    endtask

    task automatic set_flags(logic [3:0] f);
        @(negedge clk);
        flag_we = 1'b1; flag_in = f;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    task automatic set_ie(logic [1:0] e);
        @(negedge clk);
        ie_we = 1'b1; ie_in = e;
        @(negedge clk);
        ie_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 sp", 16'(sp), 16'h0001);
        check("R1 status", 16'(status), 16'h0000);
        check("R1 cond", 16'(cond_flags), 16'h0000);
        check("R1 busy", 16'(busy), 16'h0000);
        check("R1 wrap", 16'(wrap_err), 16'h0000);

        // R2 pushes, R3 LIFO pops
        issue(3'd1, 8'h11, 16'h0); check("R2 sp", 16'(sp), 16'h0002);
        issue(3'd1, 8'h22, 16'h0); check("R2 sp", 16'(sp), 16'h0003);
        issue(3'd1, 8'h33, 16'h0); check("R2 sp", 16'(sp), 16'h0004);
        expect_item(1'b0, 16'h0033, "R3 pop1");
        expect_item(1'b0, 16'h0022, "R3 pop2");
        expect_item(1'b0, 16'h0011, "R3 pop3");
        repeat (3) issue(3'd2, 8'h00, 16'h0);
        check("R3 sp", 16'(sp), 16'h0001);

        // R9 status layout
        set_flags(4'b1010);
        check("R9 status flags", 16'(status), 16'h00A0);
        check("R9 cond", 16'(cond_flags), 16'h000A);
        set_ie(2'b11);
        check("R9 status ie", 16'(status), 16'h00AC);

        // R5 call with R11 push dropped during busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_ret_addr = 16'h1234;
        @(negedge clk);
        check("R5 busy", 16'(busy), 16'h0001);
        cmd_op = 3'd1; cmd_data = 8'hEE;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        check("R5 busy end", 16'(busy), 16'h0000);
        check("R11 sp after call", 16'(sp), 16'h0003);
        expect_item(1'b1, 16'h1234, "R6 ret addr");
        issue(3'd5, 8'h00, 16'h0);
        check("R6 sp", 16'(sp), 16'h0001);

        // R5 byte order via pops
        issue(3'd3, 8'h00, 16'hBEEF);
        expect_item(1'b0, 16'h00BE, "R5 high byte on top");
        expect_item(1'b0, 16'h00EF, "R5 low byte below");
        repeat (2) issue(3'd2, 8'h00, 16'h0);

        // R7 interrupt entry, R8 return-from-interrupt
        issue(3'd4, 8'h00, 16'h5A3C);
        check("R7 sp", 16'(sp), 16'h0004);
        check("R7 ie cleared", 16'(status), 16'h00A0);
        set_flags(4'b0101);
        check("R9 status new", 16'(status), 16'h0050);
        expect_item(1'b1, 16'h5A3C, "R8 ret addr");
        issue(3'd6, 8'h00, 16'h0);
        check("R8 status restored", 16'(status), 16'h00AC);
        check("R8 sp", 16'(sp), 16'h0001);

        // R7 stacking order via pops
        issue(3'd4, 8'h00, 16'h5A3C);
        expect_item(1'b0, 16'h00AC, "R7 status on top");
        expect_item(1'b0, 16'h005A, "R7 addr high");
        expect_item(1'b0, 16'h003C, "R7 addr low");
        repeat (3) issue(3'd2, 8'h00, 16'h0);
        check("R7 status kept", 16'(status), 16'h00A0);

        // R4 load priority over a same-cycle push
        @(negedge clk);
        sp_load = 1'b1; sp_load_val = 8'h80; cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 8'h99;
        @(negedge clk);
        sp_load = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
        check("R4 load", 16'(sp), 16'h0080);
        // R4 load ignored while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_ret_addr = 16'hCAFE;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; sp_load = 1'b1; sp_load_val = 8'h10;
        @(negedge clk);
        sp_load = 1'b0;
        check("R4 load ignored busy", 16'(sp), 16'h0082);

        // R10 wrap
        check("R10 no wrap yet", 16'(wrap_err), 16'h0000);
        load_sp(8'hFF);
        issue(3'd1, 8'h77, 16'h0);
        check("R10 push wrap sp", 16'(sp), 16'h0000);
        check("R10 wrap set", 16'(wrap_err), 16'h0001);
        expect_item(1'b0, 16'h0077, "R10 data at 00");
        issue(3'd2, 8'h00, 16'h0);
        check("R10 pop wrap sp", 16'(sp), 16'h00FF);
        check("R10 sticky", 16'(wrap_err), 16'h0001);

        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", 16'(exp_val.size()), 16'h0000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule